// File: doc/BRIEF.md
# Host/Engine Access Arbiter with Weighted Engine Bursts

This block sits in front of a memory access engine. It decides which of two requesters issues the next memory access. One is the host, which makes direct memory requests. The other is a streaming data engine that fills or drains a buffer against one chip-select. Each requester raises a request line together with a chip-select ID. The arbiter answers with a one-cycle grant pulse to the winner. In the same cycle it presents a single access, tagged with the destination chip-select and the source, to the access engine. Only one access is ever in flight. The arbiter waits for the access engine's done pulse before it makes the next decision.

By default the engine has strict lowest priority, so the host never waits behind it. A mode bit switches on a weighted round-robin scheme. In that mode the engine gets a turn after every host access. Each time it wins, it may keep the bus for a programmable number of consecutive accesses. This keeps it from being starved when the host streams back-to-back accesses to another chip-select. When the host targets the same chip-select as the engine, the host keeps fixed priority in either mode.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset, and until a request is sampled, host_gnt, eng_gnt and acc_valid are all low.
- R2: A grant is a one-cycle pulse on host_gnt or eng_gnt, never both. acc_valid pulses in the same cycle. acc_cs carries the winner's chip-select ID, and acc_src is 0 for the host and 1 for the engine.
- R3: At most one access is outstanding. After a grant, no further grant is issued until acc_done has been seen high.
- R4: With rr_mode low and both requesting, the host is always granted ahead of the engine.
- R5: The engine is granted whenever it requests and the host does not.
- R6: With rr_mode high, the host and engine requesting different chip-selects, and the engine pending, the engine wins the decision right after a host access.
- R7: With rr_mode high, once granted the engine keeps winning for rr_weight consecutive grants while it keeps requesting. After that, a pending host request to a different chip-select wins.
- R8: An rr_weight of 0 behaves as a weight of 1.
- R9: If the engine drops its request before its weight is used up, its turn ends and a pending host request is granted next.
- R10: When host_cs equals eng_cs, a pending host request wins over the engine even with rr_mode high.
- R11: In round-robin mode, the first decision after reset between two pending requesters goes to the host.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rr_mode | input | 1 | 1 enables the weighted round-robin scheme |
| rr_weight | input | WT_W | Engine accesses per turn (0 treated as 1) |
| host_req | input | 1 | Host has an access pending |
| host_cs | input | CS_W | Host destination chip-select |
| host_gnt | output | 1 | One-cycle grant to the host |
| eng_req | input | 1 | Engine has an access pending |
| eng_cs | input | CS_W | Engine target chip-select |
| eng_gnt | output | 1 | One-cycle grant to the engine |
| acc_valid | output | 1 | One-cycle access issue to the access engine |
| acc_cs | output | CS_W | Chip-select of the issued access |
| acc_src | output | 1 | Source of the issued access: 0 host, 1 engine |
| acc_done | input | 1 | Pulse from the access engine when the access ends |

## Verification
The hardest situation to reach is a long interleaving in round-robin mode. It needs the host and the engine both requesting continuously, so that burst counting, the turn after each host access and the weight limit all come into play. The bench reaches it with requester agents that keep their request high until a preloaded number of grants has been served. A responder answers each access after a fixed latency. Preloaded engine counts that are shorter than the weight force an early end of the engine's turn. Equal chip-select IDs on both agents produce the same-target case.

// File: rtl/arb_pkg.sv
// Shared types for the host/engine access arbiter.
package arb_pkg;
    typedef enum logic {
        SRC_HOST = 1'b0,
        SRC_ENG  = 1'b1
    } src_e;
endpackage

// File: rtl/arb_pick.sv
// Combinational winner selection.
// Assumes burst_cnt counts engine grants since the last host grant and
// saturates at all ones. last_host is set when the previous grant went to the host.
module arb_pick #(
    parameter int CS_W = 3,
    parameter int WT_W = 4
) (
    input  logic            rr_mode,
    input  logic [WT_W-1:0] rr_weight,
    input  logic            host_req,
    input  logic [CS_W-1:0] host_cs,
    input  logic            eng_req,
    input  logic [CS_W-1:0] eng_cs,
    input  logic            last_host,
    input  logic [WT_W-1:0] burst_cnt,
    output logic            pick_valid,
    output logic            pick_eng
);
    logic [WT_W-1:0] wt_eff;
    logic            diff_cs;
    logic            eng_turn;

    // Effective weight: zero is promoted to one.
    always_comb wt_eff = (rr_weight == '0) ? WT_W'(1) : rr_weight;

    // Decide whether the engine may pre-empt a pending host request.
    always_comb begin
        diff_cs    = (host_cs != eng_cs);
        eng_turn   = rr_mode && diff_cs && (last_host || (burst_cnt < wt_eff));
        pick_valid = host_req || eng_req;
        pick_eng   = eng_req && (!host_req || eng_turn);
    end
endmodule

// File: rtl/arb_burst.sv
// Tracks the source of the last grant and how many engine grants
// have been made since the last host grant. Reset leaves the counter saturated,
// so that no engine turn is open at start-up.
module arb_burst #(
    parameter int WT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            take_eng,
    output logic            last_host,
    output logic [WT_W-1:0] burst_cnt
);
    localparam logic [WT_W-1:0] CNT_MAX = '1;

    // Update the history on every issued grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_host <= 1'b0;
            burst_cnt <= CNT_MAX;
        end else if (take) begin
            last_host <= !take_eng;
            if (!take_eng)
                burst_cnt <= '0;
            else if (burst_cnt != CNT_MAX)
                burst_cnt <= burst_cnt + WT_W'(1);
        end
    end
endmodule

// File: rtl/arb_issue.sv
// Issues one access at a time. When idle and a winner exists, it registers a
// one-cycle grant and access pulse, then waits for acc_done before becoming idle again.
module arb_issue #(
    parameter int CS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pick_valid,
    input  logic            pick_eng,
    input  logic [CS_W-1:0] host_cs,
    input  logic [CS_W-1:0] eng_cs,
    input  logic            acc_done,
    output logic            take,
    output logic            host_gnt,
    output logic            eng_gnt,
    output logic            acc_valid,
    output logic [CS_W-1:0] acc_cs,
    output logic            acc_src
);
    import arb_pkg::*;

    logic busy;

    // A grant is taken only when nothing is outstanding.
    always_comb take = !busy && pick_valid;

    // Outstanding-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (take)
            busy <= 1'b1;
        else if (acc_done)
            busy <= 1'b0;
    end

    // Registered grant pulses and access descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_gnt  <= 1'b0;
            eng_gnt   <= 1'b0;
            acc_valid <= 1'b0;
            acc_cs    <= '0;
            acc_src   <= SRC_HOST;
        end else begin
            host_gnt  <= take && !pick_eng;
            eng_gnt   <= take && pick_eng;
            acc_valid <= take;
            if (take) begin
                acc_cs  <= pick_eng ? eng_cs : host_cs;
                acc_src <= pick_eng ? SRC_ENG : SRC_HOST;
            end
        end
    end
endmodule

// File: rtl/mem_req_arbiter.sv
// Top: arbitrates host and streaming-engine requests toward a memory access
// engine. Assumes requesters hold req until they no longer need accesses, and
// that the access engine returns exactly one acc_done per issued access.
module mem_req_arbiter #(
    parameter int CS_W = 3,
    parameter int WT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rr_mode,
    input  logic [WT_W-1:0] rr_weight,
    input  logic            host_req,
    input  logic [CS_W-1:0] host_cs,
    output logic            host_gnt,
    input  logic            eng_req,
    input  logic [CS_W-1:0] eng_cs,
    output logic            eng_gnt,
    output logic            acc_valid,
    output logic [CS_W-1:0] acc_cs,
    output logic            acc_src,
    input  logic            acc_done
);
    logic            pick_valid;
    logic            pick_eng;
    logic            take;
    logic            last_host;
    logic [WT_W-1:0] burst_cnt;

    arb_pick #(.CS_W(CS_W), .WT_W(WT_W)) u_pick (
        .rr_mode    (rr_mode),
        .rr_weight  (rr_weight),
        .host_req   (host_req),
        .host_cs    (host_cs),
        .eng_req    (eng_req),
        .eng_cs     (eng_cs),
        .last_host  (last_host),
        .burst_cnt  (burst_cnt),
        .pick_valid (pick_valid),
        .pick_eng   (pick_eng)
    );

    arb_burst #(.WT_W(WT_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .take_eng  (pick_eng),
        .last_host (last_host),
        .burst_cnt (burst_cnt)
    );

    arb_issue #(.CS_W(CS_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_eng   (pick_eng),
        .host_cs    (host_cs),
        .eng_cs     (eng_cs),
        .acc_done   (acc_done),
        .take       (take),
        .host_gnt   (host_gnt),
        .eng_gnt    (eng_gnt),
        .acc_valid  (acc_valid),
        .acc_cs     (acc_cs),
        .acc_src    (acc_src)
    );
endmodule

// File: rtl/mem_req_arbiter_checker.sv
// Port-level properties of the arbiter, bound to every instance of the top module.
module mem_req_arbiter_checker #(
    parameter int CS_W = 3,
    parameter int WT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rr_mode,
    input logic            host_req,
    input logic [CS_W-1:0] host_cs,
    input logic            host_gnt,
    input logic            eng_req,
    input logic [CS_W-1:0] eng_cs,
    input logic            eng_gnt,
    input logic            acc_valid,
    input logic [CS_W-1:0] acc_cs,
    input logic            acc_done
);
    logic outstanding;

    // Independent record of whether an access is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (host_gnt || eng_gnt)
            outstanding <= 1'b1;
        else if (acc_done)
            outstanding <= 1'b0;
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({host_gnt, eng_gnt}) <= 1); // R2

    AST_VALID_WITH_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt || eng_gnt) |-> acc_valid); // R2

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !(host_gnt || eng_gnt)); // R3

    AST_HOST_CS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (acc_cs == $past(host_cs))); // R2

    AST_ENG_CS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_gnt |-> (acc_cs == $past(eng_cs))); // R2

    AST_FIXED_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_gnt && !$past(rr_mode)) |-> !$past(host_req)); // R4

    AST_SAME_CS_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_gnt && ($past(host_cs) == $past(eng_cs))) |-> !$past(host_req)); // R10

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt |-> $past(host_req)) and (eng_gnt |-> $past(eng_req))); // R5
endmodule

bind mem_req_arbiter mem_req_arbiter_checker #(.CS_W(CS_W), .WT_W(WT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rr_mode   (rr_mode),
    .host_req  (host_req),
    .host_cs   (host_cs),
    .host_gnt  (host_gnt),
    .eng_req   (eng_req),
    .eng_cs    (eng_cs),
    .eng_gnt   (eng_gnt),
    .acc_valid (acc_valid),
    .acc_cs    (acc_cs),
    .acc_done  (acc_done)
);

// File: tb/mem_req_arbiter_bench.sv
// Scoreboard bench: each case pushes the expected grant order into a queue.
// A monitor pops one entry per observed grant and compares it.
module mem_req_arbiter_bench;
    localparam int CS_W = 3;
    localparam int WT_W = 4;

    typedef struct {
        logic            eng;
        logic [CS_W-1:0] cs;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rr_mode = 1'b0;
    logic [WT_W-1:0] rr_weight = '0;
    logic [CS_W-1:0] host_cs = '0;
    logic [CS_W-1:0] eng_cs = '0;
    logic            host_gnt, eng_gnt, acc_valid, acc_src;
    logic [CS_W-1:0] acc_cs;
    logic            acc_done = 1'b0;

    // Requester agents: request while grants remain to be served.
    int unsigned host_left = 0, eng_left = 0;
    int unsigned load_h = 0, load_e = 0;
    logic        load = 1'b0;
    logic        host_req, eng_req;
    int unsigned lat = 0;

    exp_t exp_q[$];
    int   checks = 0, fails = 0;
    logic monitor_on = 1'b0;

    always #2 clk = ~clk;

    assign host_req = (host_left != 0);
    assign eng_req  = (eng_left != 0);

    mem_req_arbiter #(.CS_W(CS_W), .WT_W(WT_W)) u_mem_req_arbiter (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .rr_weight(rr_weight),
        .host_req(host_req), .host_cs(host_cs), .host_gnt(host_gnt),
        .eng_req(eng_req), .eng_cs(eng_cs), .eng_gnt(eng_gnt),
        .acc_valid(acc_valid), .acc_cs(acc_cs), .acc_src(acc_src),
        .acc_done(acc_done)
    );

    // Agents consume one pending access per grant.
    always_ff @(posedge clk) begin
        if (load) begin
            host_left <= load_h;
            eng_left  <= load_e;
        end else begin
            if (host_gnt && host_left != 0) host_left <= host_left - 1;
            if (eng_gnt && eng_left != 0)   eng_left  <= eng_left - 1;
        end
    end

    // Access-engine model: done pulse a few cycles after each issued access.
    always_ff @(posedge clk) begin
        acc_done <= 1'b0;
        if (acc_valid)
            lat <= 3;
        else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) acc_done <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor: compares every grant against the scoreboard at the falling edge.
    initial begin
        logic busy_seen;
        busy_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (monitor_on && (host_gnt || eng_gnt)) begin
                exp_t e;
                check(!busy_seen, "R3", "grant while outstanding", 1, 0);
                check(!(host_gnt && eng_gnt) && acc_valid, "R2", "grant pulse shape",
                      int'({host_gnt, eng_gnt, acc_valid}), 3);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected grant", int'(eng_gnt), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(eng_gnt == e.eng && acc_src == e.eng && acc_cs == e.cs, e.tag,
                          "source/cs", int'({acc_src, acc_cs}), int'({e.eng, e.cs}));
                end
                busy_seen = 1'b1;
            end else if (acc_done) begin
                busy_seen = 1'b0;
            end
        end
    end

    // Driver: push the expected order, then load the agents and wait for completion.
    task automatic run_case(input bit rr, input logic [WT_W-1:0] wt,
                            input int unsigned nh, input logic [CS_W-1:0] hc,
                            input int unsigned ne, input logic [CS_W-1:0] ec,
                            input string order, input string tag);
        exp_t e;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rr_mode = rr; rr_weight = wt; host_cs = hc; eng_cs = ec;
        for (int i = 0; i < order.len(); i++) begin
            e.eng = (order[i] == "E");
            e.cs  = e.eng ? ec : hc;
            e.tag = tag;
            exp_q.push_back(e);
        end
        load_h = nh; load_e = ne; load = 1'b1;
        @(posedge clk);
        #1 load = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && host_left == 0 && eng_left == 0 && lat == 0 && !acc_done)
                break;
        end
        check(exp_q.size() == 0, tag, "grants missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs in and right after reset
        check(!host_gnt && !eng_gnt && !acc_valid, "R1", "outputs in reset",
              int'({host_gnt, eng_gnt, acc_valid}), 0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!host_gnt && !eng_gnt && !acc_valid, "R1", "outputs idle after reset",
              int'({host_gnt, eng_gnt, acc_valid}), 0);
        monitor_on = 1'b1;
        // R4: fixed priority, host first
        run_case(1'b0, 4'd2, 3, 3'd1, 2, 3'd5, "HHHEE", "R4");
        // R5: engine alone
        run_case(1'b0, 4'd2, 0, 3'd1, 2, 3'd5, "EE", "R5");
        // R6/R7/R11: weight 2 interleaving
        run_case(1'b1, 4'd2, 4, 3'd0, 4, 3'd6, "HEEHEEHH", "R7");
        // R8: zero weight acts as one
        run_case(1'b1, 4'd0, 3, 3'd2, 3, 3'd4, "HEHEHE", "R8");
        // R9: engine ends its turn early
        run_case(1'b1, 4'd3, 3, 3'd3, 1, 3'd7, "HEHH", "R9");
        // R10: same chip-select keeps host first
        run_case(1'b1, 4'd2, 2, 3'd2, 2, 3'd2, "HHEE", "R10");
        // R6: single host access then engine takes its turn
        run_case(1'b1, 4'd1, 2, 3'd1, 2, 3'd3, "HEHE", "R6");
        // R11: first round-robin decision goes to the host
        run_case(1'b1, 4'd15, 1, 3'd4, 2, 3'd0, "HEE", "R11");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule